// File: doc/BRIEF.md
# Double-Buffered Memory Window Remapper

This block turns word offsets from two address windows into physical word addresses of one shared culling memory. The first window is a ping-pong window. It has no storage of its own. Each access to it is sent to one of two copies kept in a reserved region at the bottom of physical memory. The second window is a low window. It is single-buffered and passes straight through, but its usable part starts above the reserved region.

A configuration bank holds three values:
- the ping-pong area size, in 32-bit words;
- the combined ping-pong plus update area size, in words;
- a flag word whose offline bit rejects writes that come from an external source.

The reserved region is twice the combined size. Copy n starts at word n × combined size. A flip strobe marks the ping-pong event. On each flip, a select bit toggles and the pending configuration becomes active. The host port always targets copy `select` and the renderer port always targets the opposite copy, so a frame being rendered is never disturbed by host writes or by configuration changes.

Top module: `pingpong_remap`

## Requirements
- R1: After reset, select is 0 and all configuration values are 0. Any ping-pong window access then reports a range error, and a low-window access at offset k maps to physical word k with no error.
- R2: Configuration writes decode the byte offset as follows:
  - 0x0 sets the ping-pong size;
  - 0x4 sets the flag word;
  - 0x8 sets the combined size;
  - every other offset is ignored.
  A written value only takes effect at the next flip strobe. If a write and a flip fall in the same cycle, the flip loads the value that was pending before that write.
- R3: Each flip strobe toggles select. The host port uses copy `select` and the renderer port uses copy `~select`.
- R4: A ping-pong window access (window code 0) with offset k maps to physical word copy × combined + k.
- R5: A ping-pong window access with offset at or above the active ping-pong size raises the range error, and the host write enable stays low.
- R6: A low-window access (window code 1) with offset k maps to word k and raises the range error when k < 2 × combined. For example, with combined 0x18000, offset 0x2FFFF is an error and offset 0x30000 (byte 0xC0000) is not.
- R7: Any mapped address at or beyond the physical span raises the range error. The span is 2^ADDR_W words, or half that when HALF_MEM is 1.
- R8: When bit OFFLINE_BIT (default 1) of the active flag word is set, a host write marked as externally sourced is dropped: the write enable is low and no range error is raised. Mapping and reads are unaffected.
- R9: The renderer port follows the same mapping and range rules as the host port, but uses the opposite copy and its own error output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| flip | input | 1 | Ping-pong event strobe |
| host_valid | input | 1 | Host access valid |
| host_we | input | 1 | Host access is a write |
| host_ext | input | 1 | Host write is externally sourced |
| host_win | input | 1 | Host window: 0 ping-pong, 1 low |
| host_off | input | ADDR_W | Host word offset within the window |
| host_phys | output | ADDR_W | Host physical word address |
| host_err | output | 1 | Host range error |
| host_wr_en | output | 1 | Qualified host write enable |
| rd_win | input | 1 | Renderer window: 0 ping-pong, 1 low |
| rd_off | input | ADDR_W | Renderer word offset within the window |
| rd_phys | output | ADDR_W | Renderer physical word address |
| rd_err | output | 1 | Renderer range error |

## Verification
A wrong select bit makes the host and the renderer point at the same copy, or swaps them. This shows on the physical address outputs in the same cycle as the first access after the faulty flip. A configuration value that is wrong, or that is applied early, moves the range-error boundaries and the copy base on the first combinational access after the clock edge where it was loaded. Because of this, every flip is followed by accesses that probe both sides of each boundary. A missed offline gate shows as a raised write enable on the next externally sourced write.

// File: rtl/remap_pkg.sv
package remap_pkg;
   typedef enum logic {
      WIN_PP  = 1'b0,
      WIN_LOW = 1'b1
   } win_e;

   localparam logic [3:0] CFG_PP_SIZE  = 4'h0;
   localparam logic [3:0] CFG_FLAGS    = 4'h4;
   localparam logic [3:0] CFG_COMBINED = 4'h8;
endpackage

// File: rtl/remap_cfg.sv
module remap_cfg
   import remap_pkg::*;
#(
   parameter int ADDR_W      = 20,
   parameter int OFFLINE_BIT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [3:0]        cfg_addr,
   input  logic [31:0]       cfg_wdata,
   input  logic              flip,
   output logic [ADDR_W-1:0] act_pp,
   output logic [ADDR_W-1:0] act_comb,
   output logic              act_offline,
   output logic              sel
);
   logic [ADDR_W-1:0] pend_pp, pend_comb;
   logic [31:0]       pend_flags;
   logic [31:0]       act_flags;

   // Pending (shadow) copy of the configuration, written at any time.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_pp    <= '0;
         pend_comb  <= '0;
         pend_flags <= '0;
      end else if (cfg_we) begin
         unique case (cfg_addr)
            CFG_PP_SIZE:  pend_pp    <= cfg_wdata[ADDR_W-1:0];
            CFG_FLAGS:    pend_flags <= cfg_wdata;
            CFG_COMBINED: pend_comb  <= cfg_wdata[ADDR_W-1:0];
            default: ;
         endcase
      end
   end

   // Active copy: loaded, and select toggled, only at the ping-pong event.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_pp    <= '0;
         act_comb  <= '0;
         act_flags <= '0;
         sel       <= 1'b0;
      end else if (flip) begin
         act_pp    <= pend_pp;
         act_comb  <= pend_comb;
         act_flags <= pend_flags;
         sel       <= ~sel;
      end
   end

   assign act_offline = act_flags[OFFLINE_BIT];
endmodule

// File: rtl/remap_lane.sv
module remap_lane
   import remap_pkg::*;
#(
   parameter int ADDR_W   = 20,
   parameter bit HALF_MEM = 1'b0
) (
   input  logic              win,
   input  logic [ADDR_W-1:0] off,
   input  logic              copy,
   input  logic [ADDR_W-1:0] pp_size,
   input  logic [ADDR_W-1:0] comb,
   output logic [ADDR_W-1:0] phys,
   output logic              err
);
   localparam int WW = ADDR_W + 2;

   logic [WW-1:0] span;
   logic [WW-1:0] base, sum, gap;
   logic          win_err;

   generate
      if (HALF_MEM) begin : g_half
         assign span = WW'(1) << (ADDR_W - 1);
      end else begin : g_full
         assign span = WW'(1) << ADDR_W;
      end
   endgenerate

   always_comb begin
      base    = copy ? WW'(comb) : '0;
      gap     = WW'(comb) << 1;
      win_err = 1'b0;
      if (win == WIN_PP) begin
         sum     = base + WW'(off);
         win_err = (off >= pp_size);
      end else begin
         sum     = WW'(off);
         win_err = (WW'(off) < gap);
      end
   end

   assign phys = sum[ADDR_W-1:0];
   assign err  = win_err || (sum >= span);
endmodule

// File: rtl/pingpong_remap.sv
module pingpong_remap
   import remap_pkg::*;
#(
   parameter int ADDR_W      = 20,
   parameter bit HALF_MEM    = 1'b0,
   parameter int OFFLINE_BIT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [3:0]        cfg_addr,
   input  logic [31:0]       cfg_wdata,
   input  logic              flip,
   input  logic              host_valid,
   input  logic              host_we,
   input  logic              host_ext,
   input  logic              host_win,
   input  logic [ADDR_W-1:0] host_off,
   output logic [ADDR_W-1:0] host_phys,
   output logic              host_err,
   output logic              host_wr_en,
   input  logic              rd_win,
   input  logic [ADDR_W-1:0] rd_off,
   output logic [ADDR_W-1:0] rd_phys,
   output logic              rd_err
);
   generate
      if (ADDR_W < 4 || ADDR_W > 30) begin : g_bad_width
         $error("ADDR_W out of supported range");
      end
      if (OFFLINE_BIT < 0 || OFFLINE_BIT > 31) begin : g_bad_bit
         $error("OFFLINE_BIT must index the 32-bit flag word");
      end
   endgenerate

   logic [ADDR_W-1:0] act_pp, act_comb;
   logic              act_offline, sel;

   remap_cfg #(.ADDR_W(ADDR_W), .OFFLINE_BIT(OFFLINE_BIT)) u_cfg (
      .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .flip,
      .act_pp, .act_comb, .act_offline, .sel
   );

   remap_lane #(.ADDR_W(ADDR_W), .HALF_MEM(HALF_MEM)) u_host (
      .win(host_win), .off(host_off), .copy(sel),
      .pp_size(act_pp), .comb(act_comb),
      .phys(host_phys), .err(host_err)
   );

   remap_lane #(.ADDR_W(ADDR_W), .HALF_MEM(HALF_MEM)) u_rend (
      .win(rd_win), .off(rd_off), .copy(~sel),
      .pp_size(act_pp), .comb(act_comb),
      .phys(rd_phys), .err(rd_err)
   );

   assign host_wr_en = host_valid && host_we && !host_err
                       && !(act_offline && host_ext);
endmodule

// File: rtl/remap_checker.sv
module remap_checker #(
   parameter int ADDR_W   = 20,
   parameter bit HALF_MEM = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              flip,
   input logic              sel,
   input logic [ADDR_W-1:0] act_pp,
   input logic [ADDR_W-1:0] act_comb,
   input logic              act_offline,
   input logic              host_we,
   input logic              host_ext,
   input logic              host_win,
   input logic [ADDR_W-1:0] host_off,
   input logic [ADDR_W-1:0] host_phys,
   input logic              host_err,
   input logic              host_wr_en,
   input logic              rd_win,
   input logic [ADDR_W-1:0] rd_off,
   input logic [ADDR_W-1:0] rd_phys,
   input logic              rd_err
);
   localparam logic [ADDR_W:0] SPAN = HALF_MEM ? ((ADDR_W+1)'(1) << (ADDR_W-1))
                                               : ((ADDR_W+1)'(1) << ADDR_W);

   assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !flip |=> ($stable(act_pp) && $stable(act_comb) && $stable(act_offline)));

   assert_sel_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      flip |=> (sel != $past(sel)));

   assert_copies_apart_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (host_win == 1'b0 && rd_win == 1'b0 && host_off == rd_off
       && !host_err && !rd_err && act_comb != '0) |-> (host_phys != rd_phys));

   assert_range_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr_en |-> (!host_err && host_we));

   assert_low_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (host_win == 1'b1 && !host_err) |-> (host_phys == host_off));

   assert_span_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !host_err |-> ({1'b0, host_phys} < SPAN));

   assert_offline_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (act_offline && host_ext) |-> !host_wr_en);
endmodule

bind pingpong_remap remap_checker #(.ADDR_W(ADDR_W), .HALF_MEM(HALF_MEM)) u_chk (
   .clk, .rst_n, .flip, .sel, .act_pp, .act_comb, .act_offline,
   .host_we, .host_ext, .host_win, .host_off, .host_phys, .host_err, .host_wr_en,
   .rd_win, .rd_off, .rd_phys, .rd_err
);

// File: tb/sim_pingpong_remap.sv
module sim_pingpong_remap;
   localparam int AW = 20;
   localparam longint SPAN = 64'd1 << AW;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_we = 0, flip = 0, host_valid = 0, host_we = 0, host_ext = 0;
   logic [3:0] cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic host_win = 0, rd_win = 0;
   logic [AW-1:0] host_off = '0, rd_off = '0;
   logic [AW-1:0] host_phys, rd_phys;
   logic host_err, host_wr_en, rd_err;

   int checks = 0, errors = 0;

   // bench model of configuration state
   longint m_pend_pp = 0, m_pend_comb = 0, m_act_pp = 0, m_act_comb = 0;
   logic [31:0] m_pend_flags = 0, m_act_flags = 0;
   logic m_sel = 0;

   always #5 clk = ~clk;

   pingpong_remap #(.ADDR_W(AW)) u0 (
      .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .flip,
      .host_valid, .host_we, .host_ext, .host_win, .host_off,
      .host_phys, .host_err, .host_wr_en,
      .rd_win, .rd_off, .rd_phys, .rd_err
   );

   function automatic longint map_sum(logic win, longint off, logic copy);
      if (win == 1'b0) return (copy ? m_act_comb : 0) + off;
      return off;
   endfunction

   function automatic logic map_err(logic win, longint off, logic copy);
      longint s = map_sum(win, off, copy);
      logic e = (win == 1'b0) ? (off >= m_act_pp) : (off < 2 * m_act_comb);
      return e || (s >= SPAN);
   endfunction

   task automatic chk(string req, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // compare all outputs against the model for current inputs
   task automatic check_all(string req);
      logic he, re, wen;
      he  = map_err(host_win, host_off, m_sel);
      re  = map_err(rd_win, rd_off, ~m_sel);
      wen = host_valid && host_we && !he && !(m_act_flags[1] && host_ext);
      chk({req, " host_phys"}, host_phys, map_sum(host_win, host_off, m_sel) & (SPAN - 1));
      chk({req, " host_err"}, host_err, he);
      chk({req, " host_wr_en"}, host_wr_en, wen);
      chk({req, " rd_phys"}, rd_phys, map_sum(rd_win, rd_off, ~m_sel) & (SPAN - 1));
      chk({req, " rd_err"}, rd_err, re);
   endtask

   // one clock: drive at negedge, check, then advance model at posedge
   task automatic step(string req);
      #1 check_all(req);
      @(posedge clk);
      if (flip) begin
         m_act_pp = m_pend_pp; m_act_comb = m_pend_comb;
         m_act_flags = m_pend_flags; m_sel = ~m_sel;
      end
      if (cfg_we) begin
         if (cfg_addr == 4'h0) m_pend_pp = cfg_wdata[AW-1:0];
         else if (cfg_addr == 4'h4) m_pend_flags = cfg_wdata;
         else if (cfg_addr == 4'h8) m_pend_comb = cfg_wdata[AW-1:0];
      end
      @(negedge clk);
      cfg_we = 0; flip = 0;
   endtask

   task automatic wcfg(logic [3:0] a, logic [31:0] d);
      cfg_we = 1; cfg_addr = a; cfg_wdata = d;
      step("R2 cfgwrite");
   endtask

   task automatic access(logic hw, longint ho, logic rw, longint ro, logic we, logic ext, string req);
      host_valid = 1; host_we = we; host_ext = ext;
      host_win = hw; host_off = ho[AW-1:0]; rd_win = rw; rd_off = ro[AW-1:0];
      step(req);
   endtask

   initial begin
      #200000;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed1234));
      @(negedge clk); @(negedge clk);
      rst_n = 1;
      // R1: reset state
      access(1'b0, 0, 1'b0, 5, 1, 0, "R1 pp after reset");
      access(1'b1, 0, 1'b1, 77, 1, 0, "R1 low after reset");
      // R2: pending only until flip
      wcfg(4'h0, 32'h100);
      wcfg(4'h8, 32'h18000);
      wcfg(4'hC, 32'hFFFFF);
      access(1'b0, 3, 1'b0, 3, 1, 0, "R2 not yet active");
      flip = 1; access(1'b1, 0, 1'b1, 0, 1, 0, "R2 flip cycle");
      // R4/R3/R9: copies
      access(1'b0, 16'h10, 1'b0, 16'h10, 1, 0, "R4 R9 copies");
      access(1'b0, 16'hFF, 1'b0, 16'hFF, 1, 0, "R5 last inside");
      access(1'b0, 16'h100, 1'b0, 16'h100, 1, 0, "R5 at limit");
      // R6: doc boundary
      access(1'b1, 20'h2FFFF, 1'b1, 20'h30000, 1, 0, "R6 gap boundary");
      flip = 1; access(1'b0, 1, 1'b0, 1, 1, 0, "R3 flip back");
      access(1'b0, 2, 1'b0, 2, 1, 0, "R3 select 0 again");
      // R7: span overflow on copy 1
      wcfg(4'h8, 32'hC0000); wcfg(4'h0, 32'hFFFFF);
      flip = 1; access(1'b0, 0, 1'b0, 0, 1, 0, "R7 flip");
      access(1'b0, 20'h3FFFF, 1'b0, 20'h3FFFF, 1, 0, "R7 last in span");
      access(1'b0, 20'h40000, 1'b0, 20'h40000, 1, 0, "R7 beyond span");
      // R8: offline flag
      wcfg(4'h4, 32'h2); wcfg(4'h8, 32'h100); wcfg(4'h0, 32'h80);
      flip = 1; access(1'b0, 4, 1'b0, 4, 1, 1, "R8 flip");
      access(1'b0, 4, 1'b0, 4, 1, 1, "R8 ext dropped");
      access(1'b0, 4, 1'b0, 4, 1, 0, "R8 internal kept");
      access(1'b1, 20'h300, 1'b1, 20'h300, 0, 1, "R8 read ok");
      // R2: write and flip in same cycle
      wcfg(4'h0, 32'h40);
      cfg_we = 1; cfg_addr = 4'h0; cfg_wdata = 32'h20; flip = 1;
      access(1'b0, 0, 1'b0, 0, 1, 0, "R2 same-cycle");
      access(1'b0, 20'h30, 1'b0, 20'h30, 1, 0, "R2 old value loaded");
      // random mix
      for (int i = 0; i < 3000; i++) begin
         int r = $urandom_range(0, 15);
         if (r == 0) begin
            cfg_we = 1;
            cfg_addr = 4'($urandom_range(0, 3) * 4);
            cfg_wdata = (cfg_addr == 4'h4) ? $urandom_range(0, 3) * 2
                                           : 32'($urandom_range(0, 20'h9FFFF));
         end
         if (r == 1) flip = 1;
         begin
            longint bh = (r[0]) ? 2 * m_act_comb : m_act_pp;
            longint ho = ($urandom_range(0, 1) != 0) ? bh + $urandom_range(0, 2) - 1
                                                     : longint'($urandom_range(0, SPAN - 1));
            longint ro = ($urandom_range(0, 1) != 0) ? m_act_pp - 1 + $urandom_range(0, 1)
                                                     : longint'($urandom_range(0, SPAN - 1));
            if (ho < 0) ho = 0;
            if (ro < 0) ro = 0;
            access(1'($urandom_range(0, 1)), ho, 1'($urandom_range(0, 1)), ro,
                   1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R4 R5 R6 R9 random");
         end
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule